// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to 32 interrupt requests and turns them into two processor-facing lines: a normal interrupt and a fast interrupt. Each request comes from a hardware line, from a software-raised bit, or from both. A source takes part only while its enable bit is set. Software programs every source with a handler address and a 4-bit urgency level through a small word-addressed register bus. The hardware then picks the winning request itself, so the handler does not have to scan pending bits.

When the normal line is raised, software reads the current-address register. That read returns the handler address of the winning source. It also marks the winner's urgency level as being in service and holds the address. While a level is in service, only strictly more urgent sources can raise the normal line again, which gives nested servicing. Software writes the current-address register to end service. That write releases the most urgent in-service level.

A single source can instead be steered to the fast line. It then bypasses urgency masking completely.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the enable, fast-select, software-request and held-address registers read 0, every urgency register reads 15, and both `irqOut` and `fiqOut` are low.
- R2: A write to word 0x02 sets the enable bits where the data has a 1; zeros in the data leave bits unchanged. A write to word 0x03 clears the enable bits where the data has a 1. A read of word 0x02 returns the enable mask.
- R3: A write to word 0x05 sets software-request bits and a write to word 0x06 clears them, in both cases where the data has a 1. A read of word 0x05 returns the software bits. Word 0x00 reads the raw requests (hardware line OR software bit). Word 0x01 reads the raw requests AND the enable mask.
- R4: Word 0x04 is fast-select. A write keeps only the lowest set bit of the data, so at most one source is fast, and a read returns the stored mask. `fiqOut` is high exactly when the fast source is both requesting and enabled, whatever the in-service state.
- R5: Word 0x40+n holds the 32-bit handler address of source n. Word 0x60+n holds its urgency in data bits [3:0]. Both read back what was written; upper data bits of an urgency write are dropped.
- R6: Among the enabled, requesting, non-fast sources, the winner is the one with the smallest urgency value, where 0 is the most urgent. Ties go to the lower source number.
- R7: A read of word 0x07 while `irqOut` is high returns the winner's handler address, marks its urgency level as in service, and holds that address. A read of word 0x07 while `irqOut` is low returns the held address.
- R8: Any write to word 0x07 removes the most urgent in-service level, if there is one, and sets the held address to 0.
- R9: `irqOut` is high when a winner exists and, if any level is in service, the winner's urgency value is strictly smaller than the most urgent in-service level. A winner at an equal or less urgent level is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| hwIrq | input | 32 | Level-sensitive hardware requests, one per source |
| irqOut | output | 1 | Normal interrupt line |
| fiqOut | output | 1 | Fast interrupt line |

## Verification
The bench builds the block with its default 32 sources, 32-bit addresses and 4-bit urgency levels. At these values the top slot (word 0x5F) and urgency levels 0 to 5 can be reached within a short run. Equal-urgency ties between sources 7 and 9 show that the lower number wins. Two-deep nesting is exercised: level 0 is taken over level 2 and the levels are released in the correct order. A write to word 0x07 with nothing in service is also covered, as is the fast source being moved from one slot to another.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int SLOT_W = 5;
  localparam int BUS_AW = 8;

  localparam logic [BUS_AW-1:0] REG_RAW    = 8'h00;
  localparam logic [BUS_AW-1:0] REG_MASKED = 8'h01;
  localparam logic [BUS_AW-1:0] REG_EN_SET = 8'h02;
  localparam logic [BUS_AW-1:0] REG_EN_CLR = 8'h03;
  localparam logic [BUS_AW-1:0] REG_FAST   = 8'h04;
  localparam logic [BUS_AW-1:0] REG_SW_SET = 8'h05;
  localparam logic [BUS_AW-1:0] REG_SW_CLR = 8'h06;
  localparam logic [BUS_AW-1:0] REG_CUR    = 8'h07;
  localparam logic [2:0]        PAGE_VEC   = 3'b010;
  localparam logic [2:0]        PAGE_PRIO  = 3'b011;

  typedef struct packed {
    logic              enSet;
    logic              enClr;
    logic              fastWr;
    logic              swSet;
    logic              swClr;
    logic              vecWr;
    logic              prioWr;
    logic              ack;
    logic              pop;
    logic [SLOT_W-1:0] idx;
  } vicStrobes_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  vicStrobes_t         strb,
  input  logic [BUS_AW-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [NUM_SRC-1:0]  hwIrq,
  input  logic [DATA_W-1:0]   curAddrVal,
  output logic [DATA_W-1:0]   busRdata,
  output logic                winValid,
  output logic [PRIO_W-1:0]   winPrio,
  output logic [DATA_W-1:0]   winVec,
  output logic                fiqOut
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] enMask, fastSel, swReg, rawReq, effReq, normReq, wNs;
  logic [DATA_W-1:0]  vecTab  [NUM_SRC];
  logic [PRIO_W-1:0]  prioTab [NUM_SRC];
  logic [IDX_W-1:0]   winIdx;

  assign wNs = busWdata[NUM_SRC-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask  <= '0;
      fastSel <= '0;
      swReg   <= '0;
    end else begin
      if (strb.enSet)  enMask  <= enMask | wNs;
      if (strb.enClr)  enMask  <= enMask & ~wNs;
      if (strb.fastWr) fastSel <= wNs & (~wNs + 1'b1);
      if (strb.swSet)  swReg   <= swReg | wNs;
      if (strb.swClr)  swReg   <= swReg & ~wNs;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [DATA_W-1:0] vecQ;
    logic [PRIO_W-1:0] prioQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vecQ  <= '0;
        prioQ <= '1;
      end else begin
        if (strb.vecWr && strb.idx == SLOT_W'(s))  vecQ  <= busWdata;
        if (strb.prioWr && strb.idx == SLOT_W'(s)) prioQ <= busWdata[PRIO_W-1:0];
      end
    end
    assign vecTab[s]  = vecQ;
    assign prioTab[s] = prioQ;
  end

  assign rawReq  = hwIrq | swReg;
  assign effReq  = rawReq & enMask;
  assign normReq = effReq & ~fastSel;
  assign fiqOut  = |(effReq & fastSel);

  // Lowest urgency value wins; strict compare keeps the lower index on ties
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPrio  = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (normReq[i] && (!winValid || prioTab[i] < winPrio)) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = prioTab[i];
      end
    end
  end
  assign winVec = vecTab[winIdx];

  logic [SLOT_W-1:0] rdIdx;
  logic              rdSlotOk;
  assign rdIdx    = busAddr[SLOT_W-1:0];
  assign rdSlotOk = int'(rdIdx) < NUM_SRC;

  always_comb begin
    busRdata = '0;
    if (busAddr[BUS_AW-1:SLOT_W] == PAGE_VEC) begin
      if (rdSlotOk) busRdata = vecTab[rdIdx[IDX_W-1:0]];
    end else if (busAddr[BUS_AW-1:SLOT_W] == PAGE_PRIO) begin
      if (rdSlotOk) busRdata = DATA_W'(prioTab[rdIdx[IDX_W-1:0]]);
    end else begin
      case (busAddr)
        REG_RAW:    busRdata = DATA_W'(rawReq);
        REG_MASKED: busRdata = DATA_W'(effReq);
        REG_EN_SET: busRdata = DATA_W'(enMask);
        REG_FAST:   busRdata = DATA_W'(fastSel);
        REG_SW_SET: busRdata = DATA_W'(swReg);
        REG_CUR:    busRdata = curAddrVal;
        default:    busRdata = '0;
      endcase
    end
  end

  AST_FAST_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(fastSel)); // R4
  AST_FIQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN) fiqOut |-> ((fastSel & enMask) != '0)); // R4
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.enSet |=> ((enMask & $past(wNs)) == $past(wNs))); // R2
  AST_SW_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strb.swClr |=> ((swReg & $past(wNs)) == '0)); // R3
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (enMask != '0)); // R6
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              winValid,
  input  logic [PRIO_W-1:0] winPrio,
  input  logic [DATA_W-1:0] winVec,
  output vicStrobes_t       strb,
  output logic              irqOut,
  output logic [DATA_W-1:0] curAddrVal
);
  localparam int LVLS = 1 << PRIO_W;

  logic [LVLS-1:0]   inService;
  logic [DATA_W-1:0] heldVec;
  logic [PRIO_W:0]   topLevel;
  logic              wrAcc, rdAcc;

  assign wrAcc = busSel && busWr;
  assign rdAcc = busSel && !busWr;

  always_comb begin
    topLevel = (PRIO_W+1)'(LVLS);
    for (int l = LVLS-1; l >= 0; l--)
      if (inService[l]) topLevel = (PRIO_W+1)'(l);
  end

  assign irqOut = winValid && ({1'b0, winPrio} < topLevel);

  always_comb begin
    strb        = '0;
    strb.idx    = busAddr[SLOT_W-1:0];
    strb.enSet  = wrAcc && busAddr == REG_EN_SET;
    strb.enClr  = wrAcc && busAddr == REG_EN_CLR;
    strb.fastWr = wrAcc && busAddr == REG_FAST;
    strb.swSet  = wrAcc && busAddr == REG_SW_SET;
    strb.swClr  = wrAcc && busAddr == REG_SW_CLR;
    strb.pop    = wrAcc && busAddr == REG_CUR;
    strb.ack    = rdAcc && busAddr == REG_CUR && irqOut;
    strb.vecWr  = wrAcc && busAddr[BUS_AW-1:SLOT_W] == PAGE_VEC;
    strb.prioWr = wrAcc && busAddr[BUS_AW-1:SLOT_W] == PAGE_PRIO;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inService <= '0;
      heldVec   <= '0;
    end else if (strb.ack) begin
      inService[winPrio] <= 1'b1;
      heldVec            <= winVec;
    end else if (strb.pop) begin
      inService <= inService & (inService - 1'b1);
      heldVec   <= '0;
    end
  end

  assign curAddrVal = irqOut ? winVec : heldVec;

  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    strb.ack |=> inService[$past(winPrio)]); // R7
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    strb.ack |=> (heldVec == $past(winVec))); // R7
  AST_POP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> (heldVec == '0)); // R8
  AST_POP_SHRINK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && inService != '0) |=> ($countones(inService) == $countones($past(inService)) - 1)); // R8
  AST_NEST_STRICT: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && inService != '0) |-> !inService[winPrio]); // R9
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [BUS_AW-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] hwIrq,
  output logic               irqOut,
  output logic               fiqOut
);
  vicStrobes_t       strb;
  logic              winValid;
  logic [PRIO_W-1:0] winPrio;
  logic [DATA_W-1:0] winVec, curAddrVal;

  vic_ctrl #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .winValid(winValid), .winPrio(winPrio), .winVec(winVec),
    .strb(strb), .irqOut(irqOut), .curAddrVal(curAddrVal)
  );

  vic_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr), .busWdata(busWdata),
    .hwIrq(hwIrq), .curAddrVal(curAddrVal), .busRdata(busRdata),
    .winValid(winValid), .winPrio(winPrio), .winVec(winVec), .fiqOut(fiqOut)
  );
endmodule

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [31:0] hwIrq = '0;
  logic        irqOut, fiqOut;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .hwIrq(hwIrq),
    .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // behavioural reference state
  logic [31:0] mEn = 0, mFast = 0, mSw = 0, mHw = 0, mHeld = 0;
  logic [31:0] mVec [32];
  int          mPrio [32];
  bit          mBusy [16];

  function automatic int inServiceTop();
    for (int l = 0; l < 16; l++) if (mBusy[l]) return l;
    return 16;
  endfunction

  function automatic int pickWinner();
    int best = -1;
    logic [31:0] req = (mHw | mSw) & mEn & ~mFast;
    for (int s = 0; s < 32; s++)
      if (req[s] && (best < 0 || mPrio[s] < mPrio[best])) best = s;
    return best;
  endfunction

  function automatic bit expIrq();
    int w = pickWinner();
    return (w >= 0) && (mPrio[w] < inServiceTop());
  endfunction

  function automatic bit expFiq();
    return (((mHw | mSw) & mEn & mFast) != 0);
  endfunction

  function automatic logic [31:0] expRead(int a);
    if (a >= 'h40 && a < 'h60) return mVec[a - 'h40];
    if (a >= 'h60 && a < 'h80) return 32'(mPrio[a - 'h60]);
    case (a)
      0: return mHw | mSw;
      1: return (mHw | mSw) & mEn;
      2: return mEn;
      4: return mFast;
      5: return mSw;
      7: return expIrq() ? mVec[pickWinner()] : mHeld;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busOp(bit sel, bit wr, int a, logic [31:0] d, string tag);
    bit irqBefore;
    @(negedge clk);
    busSel = sel; busWr = wr; busAddr = 8'(a); busWdata = d; hwIrq = mHw;
    #1;
    check({tag, " irqOut"}, 32'(irqOut), 32'(expIrq()));
    check({tag, " fiqOut"}, 32'(fiqOut), 32'(expFiq()));
    if (sel && !wr) check({tag, " rdata"}, busRdata, expRead(a));
    irqBefore = expIrq();
    @(posedge clk);
    if (sel && wr) begin
      if (a >= 'h40 && a < 'h60) mVec[a - 'h40] = d;
      else if (a >= 'h60 && a < 'h80) mPrio[a - 'h60] = int'(d[3:0]);
      else case (a)
        2: mEn = mEn | d;
        3: mEn = mEn & ~d;
        4: begin
          mFast = 0;
          for (int b = 31; b >= 0; b--) if (d[b]) mFast = 32'(1) << b;
        end
        5: mSw = mSw | d;
        6: mSw = mSw & ~d;
        7: begin
          int t = inServiceTop();
          if (t < 16) mBusy[t] = 0;
          mHeld = 0;
        end
        default: ;
      endcase
    end
    if (sel && !wr && a == 7 && irqBefore) begin
      int w = pickWinner();
      mBusy[mPrio[w]] = 1;
      mHeld = mVec[w];
    end
  endtask

  task automatic wr(int a, logic [31:0] d, string tag); busOp(1, 1, a, d, tag); endtask
  task automatic rd(int a, string tag); busOp(1, 0, a, 0, tag); endtask
  task automatic idle(string tag); busOp(0, 0, 0, 0, tag); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 32; s++) begin mVec[s] = 0; mPrio[s] = 15; end
    for (int l = 0; l < 16; l++) mBusy[l] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2, "R1 enable"); rd(4, "R1 fast"); rd(5, "R1 sw"); rd(7, "R1 held");
    rd('h40, "R1 vec0"); rd('h60, "R1 prio0"); rd('h7F, "R1 prio31");

    // R2 enable set / clear
    wr(2, 32'h0000_068A, "R2 set"); rd(2, "R2 readback");
    wr(2, 32'h0, "R2 zero no effect"); rd(2, "R2 after zero");
    wr(3, 32'h0000_0002, "R2 clear"); rd(2, "R2 after clear");

    // R5 vectors and urgency
    foreach (mVec[s]) if (s == 1 || s == 3 || s == 7 || s == 9 || s == 10 || s == 20)
      wr('h40 + s, 32'h1000 + 32'(s) * 16, "R5 vec write");
    wr('h61, 0, "R5 prio1"); wr('h63, 32'hFFFF_FFF5, "R5 prio3 upper dropped");
    wr('h67, 2, "R5 prio7"); wr('h69, 2, "R5 prio9"); wr('h6A, 1, "R5 prio10");
    wr('h74, 2, "R5 prio20"); wr('h5F, 32'hDEAD_BEEF, "R5 vec31");
    rd('h47, "R5 vec7 read"); rd('h63, "R5 prio3 read"); rd('h5F, "R5 vec31 read");

    // R3 raw / masked / software bits
    mHw = 32'h0000_0008;
    wr(5, 32'h0010_0000, "R3 sw set 20");
    rd(0, "R3 raw"); rd(1, "R3 masked"); rd(5, "R3 sw read");
    wr(6, 32'h0010_0000, "R3 sw clear"); rd(5, "R3 sw after clear");

    // R6 arbitration, tie on urgency 2
    wr(5, 32'h0000_0280, "R6 raise 7 and 9"); idle("R6 winner 7");
    // R7 acknowledge and hold
    rd(7, "R7 ack vec7"); idle("R9 equal level held off");
    rd(7, "R7 held read");
    // R9 nesting
    wr(2, 32'h0000_0002, "R9 enable 1"); wr(5, 32'h0000_0002, "R9 raise 1");
    rd(7, "R9 ack nested vec1");
    wr(7, 0, "R8 pop level 0"); rd(7, "R8 held cleared");
    wr(6, 32'h0000_0002, "R9 drop 1"); idle("R9 level 2 busy");
    wr(7, 0, "R8 pop level 2"); idle("R6 winner 7 again");
    wr(6, 32'h0000_0280, "R6 drop 7 9"); idle("R6 winner 3");
    rd(7, "R7 ack vec3");

    // R4 fast routing
    wr(4, 32'h0000_0C00, "R4 two bits"); rd(4, "R4 lowest kept");
    mHw = 32'h0000_0408; idle("R4 fiq from 10");
    wr(4, 32'h0000_0008, "R4 move to 3"); idle("R4 fiq from 3");
    wr(7, 0, "R8 pop level 5"); idle("R4 3 left normal arbitration");
    wr(4, 0, "R4 none fast"); idle("R6 10 normal winner");
    wr(7, 0, "R8 pop empty"); rd(7, "R8 read after empty pop");
    mHw = 0; idle("R1 quiet");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule